// File: doc/BRIEF.md
# Priority-Based FIFO Allocation Router

This block shares four FIFOs among four requesting ports. A host gives each port a priority level. The FIFOs have fixed levels: FIFO 0 is the most urgent and FIFO 3 the least. A port may only use FIFOs whose index is at or below its own level. When a port asks to place a block of words, the router looks at the FIFOs that port may use and that no one else holds. It then sends back one of three answers: a full grant, a partial grant sized to the FIFO with the most room, or a wait.

The FIFOs report their free space as input counts. A granted FIFO stays reserved for the requesting port until that port signals that its transfer is finished. Requests that arrive in the same cycle are queued. They are then answered one per cycle, lowest port index first.

Top module: `fifo_alloc_router`

## Requirements
- R1: After reset every port level is 3 (the lowest), no request is pending, no FIFO is reserved, and the reply outputs are all zero.
- R2: A cycle with `cfg_we` high writes `cfg_level` into the level of port `cfg_port`. The new level applies to decisions from the next cycle on.
- R3: A port at level L may only be given a FIFO with index 0..L. FIFOs with a higher index are never offered to it, whatever their free space.
- R4: A candidate FIFO is one the port may use, that nobody holds, and whose free count is nonzero. The lowest-index candidate whose free count is at least the requested count wins. The reply is kind 3 (full) with `rsp_count` equal to the request.
- R5: If no candidate can hold the whole block, the reply is kind 2 (partial). It names the candidate with the largest free count, taking the lower index on a tie, and `rsp_count` equals that free count.
- R6: If there is no candidate, the reply is kind 1 (wait) with `rsp_fifo` and `rsp_count` both 0.
- R7: A `req_valid` pulse captures that port's count. The reply appears two clock edges after the pulse. Pending requests are answered one per cycle, lowest port index first.
- R8: A full or partial grant reserves the FIFO for that port. The FIFO is excluded from all decisions until the owner pulses `xfer_done`, which frees every FIFO that port holds at that edge.
- R9: A `req_valid` pulse from a port whose earlier request is still pending is ignored, including its count.
- R10: A reply is valid for exactly one cycle. With kind 0 (none), `rsp_port`, `rsp_fifo` and `rsp_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Level write enable |
| cfg_port | input | 2 | Port whose level is written |
| cfg_level | input | 2 | Level value to write |
| req_valid | input | 4 | One request pulse per port |
| req_count | input | 32 | Requested word counts, 8 bits per port, port 0 in the low bits |
| fifo_free | input | 32 | Free word counts, 8 bits per FIFO, FIFO 0 in the low bits |
| xfer_done | input | 4 | Transfer-finished pulse per port, frees that port's FIFOs |
| rsp_kind | output | 2 | Reply kind: 0 none, 1 wait, 2 partial, 3 full |
| rsp_port | output | 2 | Port the reply is for |
| rsp_fifo | output | 2 | Granted FIFO |
| rsp_count | output | 8 | Words accepted |

## Verification
The hardest state to reach is a mix where reservations, levels and free space together leave only some FIFOs as candidates. For example, a port's only reachable FIFOs may be partly held by others and partly too small. The bench gets there by first using a burst of simultaneous requests to reserve FIFOs in a known order. It then releases one owner selectively and issues a new request that can only land on the freed FIFO. Repeated requests from a port that is still waiting are sent while other ports are being served, so the ignored count can be seen in the later reply.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_WAIT = 2'd1,
    RK_PART = 2'd2,
    RK_FULL = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/frt_level_regs.sv
module frt_level_regs #(
  parameter int NPORT   = 4,
  parameter int PW      = 2,
  parameter int LW      = 2,
  parameter int RST_LVL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_port,
  input  logic [LW-1:0]     wr_level,
  output logic [NPORT*LW-1:0] lvl_flat
);
  for (genvar p = 0; p < NPORT; p++) begin : g_lvl
    logic [LW-1:0] lvl_q, lvl_d;
    logic          lvl_en;

    assign lvl_en = wr_en && (wr_port == PW'(p));

    always_comb begin
      lvl_d = lvl_q;
      if (lvl_en) lvl_d = wr_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= LW'(RST_LVL);
      else if (lvl_en) lvl_q <= lvl_d;
    end

    assign lvl_flat[p*LW +: LW] = lvl_q;
  end
endmodule

// File: rtl/frt_req_capture.sv
module frt_req_capture #(
  parameter int NPORT = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       req_valid,
  input  logic [NPORT*CNT_W-1:0] req_count,
  input  logic [NPORT-1:0]       clr,
  output logic [NPORT-1:0]       pend,
  output logic [NPORT*CNT_W-1:0] cnt_flat
);
  logic [NPORT-1:0] pend_q, pend_d, load;

  assign load   = req_valid & ~pend_q;
  assign pend_d = (pend_q & ~clr) | load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load[p]) cnt_q <= req_count[p*CNT_W +: CNT_W];
    end
    assign cnt_flat[p*CNT_W +: CNT_W] = cnt_q;
  end

  assign pend = pend_q;
endmodule

// File: rtl/frt_fifo_pick.sv
module frt_fifo_pick
  import frt_pkg::*;
#(
  parameter int NFIFO = 4,
  parameter int CNT_W = 8,
  parameter int FW    = 2
) (
  input  logic [FW-1:0]          level,
  input  logic [CNT_W-1:0]       count,
  input  logic [NFIFO*CNT_W-1:0] free_flat,
  input  logic [NFIFO-1:0]       busy,
  output rsp_kind_e              kind,
  output logic [FW-1:0]          fifo,
  output logic [CNT_W-1:0]       amount
);
  logic [CNT_W-1:0] free_a [NFIFO];
  logic             fit_hit;
  logic [FW-1:0]    fit_idx, best_idx;
  logic [CNT_W-1:0] best_free;

  for (genvar f = 0; f < NFIFO; f++) begin : g_free
    assign free_a[f] = free_flat[f*CNT_W +: CNT_W];
  end

  always_comb begin
    fit_hit   = 1'b0;
    fit_idx   = '0;
    best_free = '0;
    best_idx  = '0;
    for (int i = 0; i < NFIFO; i++) begin
      if (int'(level) >= i && !busy[i] && free_a[i] != '0) begin
        if (!fit_hit && free_a[i] >= count) begin
          fit_hit = 1'b1;
          fit_idx = FW'(i);
        end
        if (free_a[i] > best_free) begin
          best_free = free_a[i];
          best_idx  = FW'(i);
        end
      end
    end
  end

  always_comb begin
    if (fit_hit) begin
      kind   = RK_FULL;
      fifo   = fit_idx;
      amount = count;
    end else if (best_free != '0) begin
      kind   = RK_PART;
      fifo   = best_idx;
      amount = best_free;
    end else begin
      kind   = RK_WAIT;
      fifo   = '0;
      amount = '0;
    end
  end
endmodule

// File: rtl/frt_alloc_table.sv
module frt_alloc_table #(
  parameter int NPORT = 4,
  parameter int NFIFO = 4,
  parameter int PW    = 2,
  parameter int FW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [FW-1:0]    set_fifo,
  input  logic [PW-1:0]    set_port,
  input  logic [NPORT-1:0] done,
  output logic [NFIFO-1:0] busy
);
  for (genvar f = 0; f < NFIFO; f++) begin : g_slot
    logic          busy_q, busy_d;
    logic [PW-1:0] own_q, own_d;
    logic          hit;

    assign hit = set_en && (set_fifo == FW'(f));

    always_comb begin
      busy_d = busy_q;
      own_d  = own_q;
      if (hit) begin
        busy_d = 1'b1;
        own_d  = set_port;
      end else if (busy_q && done[own_q]) begin
        busy_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        own_q  <= '0;
      end else begin
        busy_q <= busy_d;
        own_q  <= own_d;
      end
    end

    assign busy[f] = busy_q;
  end
endmodule

// File: rtl/fifo_alloc_router.sv
module fifo_alloc_router
  import frt_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NFIFO = 4,
  parameter int CNT_W = 8,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int FW   = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [PW-1:0]          cfg_port,
  input  logic [FW-1:0]          cfg_level,
  input  logic [NPORT-1:0]       req_valid,
  input  logic [NPORT*CNT_W-1:0] req_count,
  input  logic [NFIFO*CNT_W-1:0] fifo_free,
  input  logic [NPORT-1:0]       xfer_done,
  output logic [1:0]             rsp_kind,
  output logic [PW-1:0]          rsp_port,
  output logic [FW-1:0]          rsp_fifo,
  output logic [CNT_W-1:0]       rsp_count
);
  logic [NPORT*FW-1:0]    lvl_flat;
  logic [NPORT-1:0]       pend, clr;
  logic [NPORT*CNT_W-1:0] cnt_flat;
  logic [NFIFO-1:0]       busy;
  logic                   sel_vld;
  logic [PW-1:0]          sel_port;
  rsp_kind_e              pick_kind;
  logic [FW-1:0]          pick_fifo;
  logic [CNT_W-1:0]       pick_amt;
  logic                   grant;

  rsp_kind_e        kind_q, kind_d;
  logic [PW-1:0]    port_q, port_d;
  logic [FW-1:0]    fifo_q, fifo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  frt_level_regs #(.NPORT(NPORT), .PW(PW), .LW(FW), .RST_LVL(NFIFO-1)) u_lvl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_port(cfg_port),
    .wr_level(cfg_level), .lvl_flat(lvl_flat)
  );

  frt_req_capture #(.NPORT(NPORT), .CNT_W(CNT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
    .clr(clr), .pend(pend), .cnt_flat(cnt_flat)
  );

  always_comb begin
    sel_vld  = 1'b0;
    sel_port = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (pend[p]) begin
        sel_vld  = 1'b1;
        sel_port = PW'(p);
      end
    end
  end

  always_comb begin
    clr = '0;
    if (sel_vld) clr[sel_port] = 1'b1;
  end

  frt_fifo_pick #(.NFIFO(NFIFO), .CNT_W(CNT_W), .FW(FW)) u_pick (
    .level(lvl_flat[sel_port*FW +: FW]),
    .count(cnt_flat[sel_port*CNT_W +: CNT_W]),
    .free_flat(fifo_free), .busy(busy),
    .kind(pick_kind), .fifo(pick_fifo), .amount(pick_amt)
  );

  assign grant = sel_vld && (pick_kind == RK_FULL || pick_kind == RK_PART);

  frt_alloc_table #(.NPORT(NPORT), .NFIFO(NFIFO), .PW(PW), .FW(FW)) u_alloc (
    .clk(clk), .rst_n(rst_n), .set_en(grant), .set_fifo(pick_fifo),
    .set_port(sel_port), .done(xfer_done), .busy(busy)
  );

  always_comb begin
    kind_d = RK_NONE;
    port_d = '0;
    fifo_d = '0;
    cnt_d  = '0;
    if (sel_vld) begin
      kind_d = pick_kind;
      port_d = sel_port;
      fifo_d = pick_fifo;
      cnt_d  = pick_amt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RK_NONE;
      port_q <= '0;
      fifo_q <= '0;
      cnt_q  <= '0;
    end else begin
      kind_q <= kind_d;
      port_q <= port_d;
      fifo_q <= fifo_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rsp_kind  = kind_q;
  assign rsp_port  = port_q;
  assign rsp_fifo  = fifo_q;
  assign rsp_count = cnt_q;
endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
  parameter int NPORT = 4,
  parameter int NFIFO = 4,
  parameter int CNT_W = 8,
  parameter int PW    = 2,
  parameter int FW    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             rsp_kind,
  input logic [PW-1:0]          rsp_port,
  input logic [FW-1:0]          rsp_fifo,
  input logic [CNT_W-1:0]       rsp_count,
  input logic [NFIFO*CNT_W-1:0] fifo_free,
  input logic [NPORT*FW-1:0]    lvl_flat,
  input logic [NFIFO-1:0]       busy
);
  logic [NFIFO*CNT_W-1:0] free_q;
  logic [NPORT*FW-1:0]    lvl_q;
  logic [NFIFO-1:0]       busy_q;
  logic                   granted;
  logic [CNT_W-1:0]       free_sel;
  logic [FW-1:0]          lvl_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0;
      lvl_q  <= '0;
      busy_q <= '0;
    end else begin
      free_q <= fifo_free;
      lvl_q  <= lvl_flat;
      busy_q <= busy;
    end
  end

  assign granted  = rsp_kind[1];
  assign free_sel = free_q[rsp_fifo*CNT_W +: CNT_W];
  assign lvl_sel  = lvl_q[rsp_port*FW +: FW];

  AST_REACH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> rsp_fifo <= lvl_sel); // R3
  AST_FULL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind == 2'd3 |-> rsp_count <= free_sel); // R4
  AST_PART_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind == 2'd2 |-> (rsp_count == free_sel) && (rsp_count != '0)); // R5
  AST_WAIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind == 2'd1 |-> (rsp_count == '0) && (rsp_fifo == '0)); // R6
  AST_NO_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> !busy_q[rsp_fifo]); // R8
  AST_HELD_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> busy[rsp_fifo]); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind == 2'd0 |-> (rsp_count == '0) && (rsp_port == '0) && (rsp_fifo == '0)); // R10
endmodule

bind fifo_alloc_router frt_checker #(
  .NPORT(NPORT), .NFIFO(NFIFO), .CNT_W(CNT_W), .PW(PW), .FW(FW)
) u_frt_checker (
  .clk(clk), .rst_n(rst_n), .rsp_kind(rsp_kind), .rsp_port(rsp_port),
  .rsp_fifo(rsp_fifo), .rsp_count(rsp_count), .fifo_free(fifo_free),
  .lvl_flat(lvl_flat), .busy(busy)
);

// File: tb/fifo_alloc_router_bench.sv
`timescale 1ns/1ps
module fifo_alloc_router_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_port, cfg_level;
  logic [3:0]  req_valid, xfer_done;
  logic [31:0] req_count, fifo_free;
  logic [1:0]  rsp_kind, rsp_port, rsp_fifo;
  logic [7:0]  rsp_count;

  int n_chk, n_fail;
  string cur_tag;

  int m_lvl[4], m_pend[4], m_cnt[4], m_busy[4], m_own[4];
  int e_kind, e_port, e_fifo, e_count;
  int sel, fit, best, bf, fr;

  fifo_alloc_router u_fifo_alloc_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_level(cfg_level), .req_valid(req_valid), .req_count(req_count),
    .fifo_free(fifo_free), .xfer_done(xfer_done), .rsp_kind(rsp_kind),
    .rsp_port(rsp_port), .rsp_fifo(rsp_fifo), .rsp_count(rsp_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin m_lvl[p] = 3; m_pend[p] = 0; m_cnt[p] = 0; end
      for (int f = 0; f < 4; f++) begin m_busy[f] = 0; m_own[f] = 0; end
      e_kind = 0; e_port = 0; e_fifo = 0; e_count = 0;
    end else begin
      sel = -1;
      for (int p = 0; p < 4; p++) if (sel < 0 && m_pend[p] != 0) sel = p;
      e_kind = 0; e_port = 0; e_fifo = 0; e_count = 0;
      if (sel >= 0) begin
        fit = -1; best = -1; bf = 0;
        for (int f = 0; f <= m_lvl[sel]; f++) begin
          fr = int'(fifo_free[f*8 +: 8]);
          if (m_busy[f] == 0 && fr > 0) begin
            if (fit < 0 && fr >= m_cnt[sel]) fit = f;
            if (fr > bf) begin bf = fr; best = f; end
          end
        end
        e_port = sel;
        if (fit >= 0) begin e_kind = 3; e_fifo = fit; e_count = m_cnt[sel]; end
        else if (best >= 0) begin e_kind = 2; e_fifo = best; e_count = bf; end
        else e_kind = 1;
      end
      for (int f = 0; f < 4; f++)
        if (m_busy[f] != 0 && xfer_done[m_own[f]]) m_busy[f] = 0;
      if (e_kind >= 2) begin m_busy[e_fifo] = 1; m_own[e_fifo] = sel; end
      for (int p = 0; p < 4; p++) begin
        if (m_pend[p] == 0 && req_valid[p]) begin
          m_pend[p] = 1; m_cnt[p] = int'(req_count[p*8 +: 8]);
        end else if (p == sel) m_pend[p] = 0;
      end
      if (cfg_we) m_lvl[cfg_port] = int'(cfg_level);
    end
  end

  task automatic check_rsp(string tag, int k, int p, int f, int c);
    n_chk++;
    if (int'(rsp_kind) != k || int'(rsp_port) != p || int'(rsp_fifo) != f || int'(rsp_count) != c) begin
      n_fail++;
      $display("FAIL %s: got kind=%0d port=%0d fifo=%0d count=%0d, expected kind=%0d port=%0d fifo=%0d count=%0d",
               tag, rsp_kind, rsp_port, rsp_fifo, rsp_count, k, p, f, c);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_rsp(cur_tag, e_kind, e_port, e_fifo, e_count);
    req_valid = '0; xfer_done = '0; cfg_we = 1'b0;
  endtask

  task automatic req(int p, int c);
    req_valid[p] = 1'b1;
    req_count[p*8 +: 8] = 8'(c);
  endtask

  task automatic set_lvl(int p, int l);
    cfg_we = 1'b1; cfg_port = 2'(p); cfg_level = 2'(l);
    step();
  endtask

  task automatic set_free(int f0, int f1, int f2, int f3);
    fifo_free = {8'(f3), 8'(f2), 8'(f1), 8'(f0)};
  endtask

  task automatic release_all();
    xfer_done = 4'hF;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; cur_tag = "R1";
    rst_n = 1'b0; cfg_we = 1'b0; cfg_port = '0; cfg_level = '0;
    req_valid = '0; xfer_done = '0; req_count = '0; fifo_free = '0;
    repeat (3) @(negedge clk);
    check_rsp("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    check_rsp("R1", 0, 0, 0, 0);

    // R1: reset level 3 reaches FIFO 3
    set_free(0, 0, 0, 5);
    req(1, 5); step(); step();
    check_rsp("R1", 3, 1, 3, 5);
    step();
    check_rsp("R10", 0, 0, 0, 0);
    release_all();

    // R2/R3: level 1 port cannot reach FIFOs 2,3
    cur_tag = "R3";
    set_lvl(2, 1);
    set_free(0, 0, 9, 9);
    req(2, 3); step(); step();
    check_rsp("R3", 1, 2, 0, 0);
    check_rsp("R2", 1, 2, 0, 0);

    // R4: skip FIFO lacking room
    cur_tag = "R4";
    set_free(4, 30, 30, 30);
    req(2, 20); step(); step();
    check_rsp("R4", 3, 2, 1, 20);
    release_all();

    // R5: partial to emptiest eligible, then tie case
    cur_tag = "R5";
    set_lvl(0, 1);
    set_free(6, 11, 200, 200);
    req(0, 50); step(); step();
    check_rsp("R5", 2, 0, 1, 11);
    release_all();
    set_free(7, 7, 200, 200);
    req(0, 50); step(); step();
    check_rsp("R5", 2, 0, 0, 7);
    release_all();

    // R7/R8: simultaneous requests, lowest port first, FIFOs reserved
    cur_tag = "R7";
    set_lvl(0, 3);
    set_lvl(2, 3);
    set_free(100, 100, 100, 100);
    req(0, 1); req(1, 1); req(2, 1); req(3, 1);
    step();
    step(); check_rsp("R7", 3, 0, 0, 1);
    step(); check_rsp("R7", 3, 1, 1, 1);
    step(); check_rsp("R8", 3, 2, 2, 1);
    step(); check_rsp("R8", 3, 3, 3, 1);
    cur_tag = "R8";
    req(0, 1); step(); step();
    check_rsp("R8", 1, 0, 0, 0);
    xfer_done[2] = 1'b1; step();
    req(3, 1); step(); step();
    check_rsp("R8", 3, 3, 2, 1);
    release_all();

    // R9: second pulse while pending is ignored
    cur_tag = "R9";
    req(0, 2); req(1, 3); step();
    req(1, 9); step();
    check_rsp("R7", 3, 0, 0, 2);
    step();
    check_rsp("R9", 3, 1, 1, 3);
    release_all();

    // R6: no space at all
    cur_tag = "R6";
    set_free(0, 0, 0, 0);
    req(1, 4); step(); step();
    check_rsp("R6", 1, 1, 0, 0);
    step();
    check_rsp("R10", 0, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule